// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Classifier

This block is a synthesizable monitor for the control strobes of an EDO DRAM with two byte lanes. It samples the row strobe, the lower and upper column strobes, write enable and output enable on a fast system clock. All of these strobes are active low. From the order in which the edges arrive, it works out which kind of memory cycle each row cycle was. It also tracks, lane by lane, whether the memory is expected to drive its data pins at that moment.

It is placed next to a DRAM controller under test. When a row cycle ends, the block emits a one-clock report. The report gives the cycle type, the byte lanes the cycle touched, and a protocol-error flag. A checker can compare this against what the controller meant to do. The per-lane drive output shows when the memory owns the data bus, so bus contention can be checked. Timing finer than one sample period is not resolved.

The effective column strobe is active while either lane strobe is low. It goes active on the first lane to fall and inactive when the last lane rises. Writes and output driving are still followed for each lane on its own.

Top module: `edo_strobe_classifier`

## Requirements
- R1: When the previous sample had the row strobe and both column strobes high, `dq_oe` is 2'b00. No report is produced while the row strobe stays high.
- R2: `cyc_valid` is high for exactly one clock, in the clock after the rising row strobe is sampled. When it is high, `cyc_type` holds one of these codes: 1 row-only refresh, 2 column-before-row refresh, 3 read, 4 early write, 5 delayed write, 6 read-modify-write, 7 read with outputs disabled.
- R3: If either column strobe is low on the sample where the row strobe falls, the cycle is reported as type 2 with `cyc_lanes` = 2'b00.
- R4: A row cycle in which no column strobe falls is reported as type 1 with `cyc_lanes` = 2'b00.
- R5: If write enable is low on the sample where the effective column strobe first falls, the cycle is type 4. `dq_oe` then stays 2'b00 for the whole cycle.
- R6: In a cycle that began as a read, write enable may fall while the effective column strobe is low. If output enable was low during a column access and is high at that moment, the cycle becomes type 6. Otherwise it becomes type 5.
- R7: A read cycle is type 3 if output enable was low during a column access, and type 7 otherwise. In every reported type other than 1 and 2, `cyc_lanes` marks each lane whose column strobe went low: bit 0 is the lower lane and bit 1 is the upper lane.
- R8: In a read cycle, lane b is driven (`dq_oe[b]`=1, while output enable is low) from the clock after its column strobe is sampled low. Driving continues after the column strobe rises. It stops in the clock after the row strobe and both column strobes are all sampled high, whichever of them rose last.
- R9: While the effective column strobe is high, a rising output enable or a falling write enable stops the driving of both lanes. Driving stays off until a column strobe falls again.
- R10: `cyc_err` is reported high with the report when the cycle is a write (type 4, 5 or 6) and its two column strobes fell on different samples within one access. A staggered read reports `cyc_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-clock report strobe at the end of a row cycle |
| cyc_type | output | 3 | Cycle type code (see R2) |
| cyc_lanes | output | 2 | Lanes touched by the cycle (bit 0 lower, bit 1 upper) |
| cyc_err | output | 1 | Staggered column strobes in a write cycle |
| dq_oe | output | 2 | Memory expected to drive each data lane |

## Verification
Some properties are checked on every cycle:
- the report is a single-clock pulse that always carries a nonzero code;
- refresh reports never name any lanes;
- an error is only ever flagged on a write type;
- nothing is driven after an all-high sample;
- an early write never drives the bus.

Other behaviour can only be shown by the bench's scenarios:
- choosing between delayed write and read-modify-write from the history of output enable;
- staggered versus simultaneous lane strobes;
- the EDO hold after the column strobe rises;
- the disable-until-next-access effect of output enable and write enable.

// File: rtl/edo_strobe_classifier.sv
module edo_strobe_classifier (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       lcas_n,
  input  logic       ucas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       cyc_valid,
  output logic [2:0] cyc_type,
  output logic [1:0] cyc_lanes,
  output logic       cyc_err,
  output logic [1:0] dq_oe
);
  localparam logic [2:0] T_RONLY = 3'd1;
  localparam logic [2:0] T_CBR   = 3'd2;
  localparam logic [2:0] T_READ  = 3'd3;
  localparam logic [2:0] T_EWR   = 3'd4;
  localparam logic [2:0] T_DWR   = 3'd5;
  localparam logic [2:0] T_RMW   = 3'd6;
  localparam logic [2:0] T_RDOFF = 3'd7;

  logic ras_q, lcas_q, ucas_q, we_q, oe_q;
  logic [2:0] cls;
  logic [1:0] lanes_acc, arm;
  logic oe_seen, single, stag;

  wire [1:0] lane_low = ~{ucas_n, lcas_n};
  wire cas_now  = |lane_low;
  wire cas_prev = ~lcas_q | ~ucas_q;
  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = ~cas_prev & cas_now;
  wire in_cycle = ~ras_q & ~ras_n;
  wire refresh_cls = (cls == T_RONLY) | (cls == T_CBR);
  wire write_cls = (cls == T_EWR) | (cls == T_DWR) | (cls == T_RMW);
  wire rd_ok = in_cycle & ((cls == T_READ) | ((cls == T_RONLY) & cas_fall & we_n));
  wire oe_rise = ~oe_q & oe_n;
  wire we_fall = we_q & ~we_n;

  assign dq_oe = arm & {2{~oe_n}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; lcas_q <= 1'b1; ucas_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1;
      cls <= T_RONLY; lanes_acc <= '0; oe_seen <= 1'b0; single <= 1'b0; stag <= 1'b0;
      arm <= '0;
      cyc_valid <= 1'b0; cyc_type <= '0; cyc_lanes <= '0; cyc_err <= 1'b0;
    end else begin
      ras_q <= ras_n; lcas_q <= lcas_n; ucas_q <= ucas_n; we_q <= we_n; oe_q <= oe_n;
      cyc_valid <= ras_rise;
      if (ras_rise) begin
        cyc_type  <= (cls == T_READ && !oe_seen) ? T_RDOFF : cls;
        cyc_lanes <= refresh_cls ? 2'b00 : lanes_acc;
        cyc_err   <= stag & write_cls;
      end
      if (ras_fall) begin
        cls <= cas_now ? T_CBR : T_RONLY;
        lanes_acc <= '0; oe_seen <= 1'b0; single <= 1'b0; stag <= 1'b0;
      end else if (in_cycle && cls != T_CBR) begin
        lanes_acc <= lanes_acc | lane_low;
        if (cas_fall) begin
          single <= lcas_n ^ ucas_n;
          if (cls == T_RONLY) cls <= we_n ? T_READ : T_EWR;
        end else if (single && (&lane_low)) begin
          stag <= 1'b1;
        end
        if (cls == T_READ && cas_now && !oe_n) oe_seen <= 1'b1;
        if (cls == T_READ && cas_now && we_fall)
          cls <= (oe_seen && oe_n) ? T_RMW : T_DWR;
      end
      for (int b = 0; b < 2; b++) begin
        if (ras_n && !cas_now) arm[b] <= 1'b0;
        else if (!cas_now && (oe_rise || we_fall)) arm[b] <= 1'b0;
        else if (lane_low[b] && !we_n) arm[b] <= 1'b0;
        else if (lane_low[b] && we_n && rd_ok) arm[b] <= 1'b1;
      end
    end
  end

  AST_STANDBY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && lcas_n && ucas_n) |-> dq_oe == 2'b00); // R1
  AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid); // R2
  AST_REPORT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> cyc_type != 3'd0); // R2
  AST_CBR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == T_CBR) |-> cyc_lanes == 2'b00); // R3
  AST_RONLY_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == T_RONLY) |-> cyc_lanes == 2'b00); // R4
  AST_EARLY_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == T_EWR && !ras_n) |-> dq_oe == 2'b00); // R5
  AST_ERR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_err) |-> (cyc_type == T_EWR || cyc_type == T_DWR || cyc_type == T_RMW)); // R10
endmodule

// File: tb/edo_strobe_classifier_tb.sv
module edo_strobe_classifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic cyc_valid, cyc_err;
  logic [2:0] cyc_type;
  logic [1:0] cyc_lanes, dq_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edo_strobe_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_lanes(cyc_lanes), .cyc_err(cyc_err), .dq_oe(dq_oe)
  );

  // fields: pre[16:15] lanes[14:13] wmode[12:11] omode[10:9] stagger[8]
  //         type[7:5] lanes_exp[4:3] dq_exp[2:1] err[0]
  localparam int NV = 14;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {2'b00, 2'b00, 2'd0, 2'd0, 1'b0, 3'd1, 2'b00, 2'b00, 1'b0},
    {2'b01, 2'b00, 2'd0, 2'd0, 1'b0, 3'd2, 2'b00, 2'b00, 1'b0},
    {2'b10, 2'b00, 2'd0, 2'd0, 1'b0, 3'd2, 2'b00, 2'b00, 1'b0},
    {2'b00, 2'b11, 2'd0, 2'd1, 1'b0, 3'd3, 2'b11, 2'b11, 1'b0},
    {2'b00, 2'b01, 2'd0, 2'd1, 1'b0, 3'd3, 2'b01, 2'b01, 1'b0},
    {2'b00, 2'b10, 2'd0, 2'd0, 1'b0, 3'd7, 2'b10, 2'b00, 1'b0},
    {2'b00, 2'b11, 2'd1, 2'd1, 1'b0, 3'd4, 2'b11, 2'b00, 1'b0},
    {2'b00, 2'b11, 2'd2, 2'd0, 1'b0, 3'd5, 2'b11, 2'b00, 1'b0},
    {2'b00, 2'b11, 2'd2, 2'd1, 1'b0, 3'd5, 2'b11, 2'b11, 1'b0},
    {2'b00, 2'b11, 2'd2, 2'd2, 1'b0, 3'd6, 2'b11, 2'b11, 1'b0},
    {2'b00, 2'b11, 2'd1, 2'd1, 1'b1, 3'd4, 2'b11, 2'b00, 1'b1},
    {2'b00, 2'b11, 2'd0, 2'd1, 1'b1, 3'd3, 2'b11, 2'b11, 1'b0},
    {2'b00, 2'b11, 2'd2, 2'd2, 1'b1, 3'd6, 2'b11, 2'b11, 1'b1},
    {2'b00, 2'b10, 2'd1, 2'd0, 1'b0, 3'd4, 2'b10, 2'b00, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report_check(input logic [16:0] v, input int idx);
    check($sformatf("R2 valid vec%0d", idx), {7'd0, cyc_valid}, 8'd1);
    check($sformatf("R2/R3/R4/R5/R6/R7 type vec%0d", idx), {5'd0, cyc_type}, {5'd0, v[7:5]});
    check($sformatf("R7 lanes vec%0d", idx), {6'd0, cyc_lanes}, {6'd0, v[4:3]});
    check($sformatf("R10 err vec%0d", idx), {7'd0, cyc_err}, {7'd0, v[0]});
    tick();
    check($sformatf("R2 pulse end vec%0d", idx), {7'd0, cyc_valid}, 8'd0);
  endtask

  task automatic run_vec(input logic [16:0] v, input int idx);
    tick(); tick();
    if (v[16:15] != 2'b00) begin
      {ucas_n, lcas_n} = ~v[16:15];
      tick(); ras_n = 1'b0; tick(); tick();
      ras_n = 1'b1; tick();
      report_check(v, idx);  // R3
      {ucas_n, lcas_n} = 2'b11; tick(); tick();
    end else begin
      ras_n = 1'b0; tick();
      if (v[12:11] == 2'd1) we_n = 1'b0;
      if (v[10:9] != 2'd0) oe_n = 1'b0;
      tick();
      if (v[14:13] != 2'b00) begin
        if (v[8]) begin
          lcas_n = 1'b0; tick(); ucas_n = 1'b0;
        end else begin
          {ucas_n, lcas_n} = ~v[14:13];
        end
        tick();
        check($sformatf("R5/R8 drive vec%0d", idx), {6'd0, dq_oe}, {6'd0, v[2:1]});
        tick();
        if (v[12:11] == 2'd2) begin
          if (v[10:9] == 2'd2) begin oe_n = 1'b1; tick(); end
          we_n = 1'b0; tick(); tick();
        end
      end
      {ucas_n, lcas_n} = 2'b11; we_n = 1'b1; oe_n = 1'b1; tick();
      ras_n = 1'b1; tick();
      report_check(v, idx);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 reset dq", {6'd0, dq_oe}, 8'd0);
    check("R2 reset valid", {7'd0, cyc_valid}, 8'd0);
    tick(); rst_n = 1'b1; tick(); tick();
    check("R1 idle no report", {7'd0, cyc_valid}, 8'd0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // EDO hold after column strobe rises, off once row strobe rises
    ras_n = 1'b0; tick(); oe_n = 1'b0; {ucas_n, lcas_n} = 2'b00; tick();
    check("R8 driven", {6'd0, dq_oe}, 8'd3);
    {ucas_n, lcas_n} = 2'b11; tick();
    check("R8 hold after cas rise", {6'd0, dq_oe}, 8'd3);
    tick();
    check("R8 still held", {6'd0, dq_oe}, 8'd3);
    ras_n = 1'b1; tick();
    check("R8 off after last rise", {6'd0, dq_oe}, 8'd0);
    oe_n = 1'b1; tick(); tick();

    // row strobe rises first, column strobe last
    ras_n = 1'b0; tick(); oe_n = 1'b0; {ucas_n, lcas_n} = 2'b00; tick();
    ras_n = 1'b1; tick();
    check("R8 held while cas low", {6'd0, dq_oe}, 8'd3);
    {ucas_n, lcas_n} = 2'b11; tick();
    check("R8 off at later cas rise", {6'd0, dq_oe}, 8'd0);
    oe_n = 1'b1; tick(); tick();

    // output enable rising while column strobe high
    ras_n = 1'b0; tick(); oe_n = 1'b0; {ucas_n, lcas_n} = 2'b00; tick();
    {ucas_n, lcas_n} = 2'b11; tick();
    check("R9 pre oe rise", {6'd0, dq_oe}, 8'd3);
    oe_n = 1'b1; tick(); oe_n = 1'b0; tick();
    check("R9 off after oe rise", {6'd0, dq_oe}, 8'd0);
    lcas_n = 1'b0; tick();
    check("R9 rearm lower on next access", {6'd0, dq_oe}, 8'd1);
    lcas_n = 1'b1; oe_n = 1'b1; tick(); ras_n = 1'b1; tick(); tick();

    // write enable falling while column strobe high
    ras_n = 1'b0; tick(); oe_n = 1'b0; {ucas_n, lcas_n} = 2'b00; tick();
    {ucas_n, lcas_n} = 2'b11; tick();
    check("R9 pre we fall", {6'd0, dq_oe}, 8'd3);
    we_n = 1'b0; tick();
    check("R9 off after we fall", {6'd0, dq_oe}, 8'd0);
    we_n = 1'b1; tick();
    check("R9 stays off", {6'd0, dq_oe}, 8'd0);
    oe_n = 1'b1; tick(); ras_n = 1'b1; tick(); tick();
    check("R1 standby open", {6'd0, dq_oe}, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule